// File: doc/BRIEF.md
# DRAM Strobe Decoder with Compressed Test Mode

This block is the control logic inside a multiplexed-address DRAM whose array stores each pair of 4-bit words as one internal 8-bit byte. It watches the row strobe, column strobe, write enable and output enable inputs. From their order it recognises normal accesses, early writes, read-modify-writes, fast page accesses and the refresh cycles. A small synthesizable byte array stands in for the cells. All strobes are sampled on a system clock, so every analog edge becomes a sampled event.

A special strobe order switches the part into a compressed test mode. In that mode a write fills all eight bits of an internal byte with one value. A read then reports only whether the eight bits agree, so a tester checks a whole byte per access. Any refresh-type cycle returns the part to normal operation.

The parameter `AW` sets the width of the multiplexed address; the array holds 2^(2*AW-1) bytes. A full-size part uses AW = 10, and the default is kept small. Row address bits and column address bits are latched on separate strobes. Column bit 0 picks the nibble within the byte: 0 selects bits 3:0 and 1 selects bits 7:4. The byte index is {row[AW-1:0], col[AW-1:1]}.

Top module: `dram_test_ctrl`

## Requirements
- R1: After reset the output-enable flag is low and the part is in normal mode, so a written nibble reads back unchanged.
- R2: A normal write stores dq_in into the nibble chosen by column bit 0 of the byte {row, col[AW-1:1]}; a normal read of that location returns it; the two nibbles of a byte are independent.
- R3: When write enable is already low at the column strobe's falling sample (early write), dq_oe stays low for the whole column-strobe-low period.
- R4: A row strobe falling sample with the column strobe and write enable both low enters test mode.
- R5: A row strobe falling sample with the column strobe low and write enable high is a refresh that leaves test mode and changes no stored data.
- R6: A row strobe cycle that ends without any column strobe fall (row-only refresh) leaves test mode.
- R7: A hidden refresh exits test mode: the column strobe is held low from a read while the row strobe rises and falls again. The read data and dq_oe stay valid through it.
- R8: In test mode a write stores dq_in[0] into all eight bits of the selected byte; dq_in[3:1] have no effect.
- R9: In test mode a read drives dq_out[2:0] = 3'b111 and dq_out[3] = 1 when all eight bits of the byte are equal, 0 otherwise.
- R10: In test mode, row bit AW-1, column bit AW-1 and column bit 0 are ignored and treated as zero. In normal mode they still select distinct storage.
- R11: If write enable falls while the column strobe is low in a read cycle, dq_in is written to the latched location. dq_out keeps the data read before the write.
- R12: dq_oe is high only in a read cycle with oe_n low, and falls on the sample after the column strobe rises.
- R13: Several column strobe cycles within one row strobe cycle (fast page) each access the latched row with a new column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| dq_in | input | 4 | Write data |
| dq_out | output | 4 | Read data or test result |
| dq_oe | output | 1 | Output drive enable |

## Verification
The bench targets the test-mode address folding. It writes through an address with the ignored bits set and reads through one with them clear. A design that decoded those bits would hit a different byte and return the wrong compare. It checks each exit path (refresh with column strobe first, row-only refresh, hidden refresh) by a read at an address whose normal result differs from any test result. A decoder that missed an exit would return a compare pattern instead of the stored nibble. Read-modify-write and early write are checked at the outputs. Wrong handling would show a changed dq_out during the write or a driven bus during an early write. Upper data bits are ignored in a test write, which the bench shows by clearing a byte with dq_in = 4'hE.

// File: rtl/dram_test_ctrl.sv
module dram_test_ctrl #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    dq_in,
  output logic [3:0]    dq_out,
  output logic          dq_oe
);
  localparam int WW    = 2*AW - 1;
  localparam int DEPTH = 1 << WW;

  logic          ras_q, cas_q, we_q;
  logic          test_mode, row_open, cas_seen;
  logic          rd_valid, wr_cyc;
  logic [AW-1:0] row_q, col_q;
  logic [3:0]    rd_data;
  logic [7:0]    mem [DEPTH];

  function automatic logic [WW-1:0] word_of(input logic [AW-1:0] r,
                                            input logic [AW-1:0] c,
                                            input logic tm);
    if (tm) return {1'b0, r[AW-2:0], 1'b0, c[AW-2:1]};
    else    return {r, c[AW-1:1]};
  endfunction

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_q & ~cas_n & row_open & ~ras_n;
  wire cas_rise = ~cas_q & cas_n;
  wire we_fall  = we_q & ~we_n;

  wire [WW-1:0] cur_word = word_of(row_q, addr, test_mode);
  wire [WW-1:0] lat_word = word_of(row_q, col_q, test_mode);
  wire [7:0]    cur_byte = mem[cur_word];
  wire          same8    = (&cur_byte) | ~(|cur_byte);
  wire [3:0]    rd_nib   = test_mode ? {same8, 3'b111}
                         : (addr[0] ? cur_byte[7:4] : cur_byte[3:0]);

  wire          wr_early = cas_fall & ~we_n;
  wire          wr_late  = rd_valid & row_open & ~cas_n & cas_q == 1'b0 & we_fall;
  wire          wr_en    = wr_early | wr_late;
  wire [WW-1:0] wr_word  = wr_early ? cur_word : lat_word;
  wire          wr_lane  = wr_early ? addr[0] : col_q[0];
  wire [7:0]    old_byte = mem[wr_word];
  wire [7:0]    wr_byte  = test_mode ? {8{dq_in[0]}}
                         : (wr_lane ? {dq_in, old_byte[3:0]} : {old_byte[7:4], dq_in});

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_word] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      we_q      <= 1'b1;
      test_mode <= 1'b0;
      row_open  <= 1'b0;
      cas_seen  <= 1'b0;
      rd_valid  <= 1'b0;
      wr_cyc    <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      rd_data   <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
      if (ras_fall) begin
        if (!cas_n) begin
          test_mode <= ~we_n;
          row_open  <= 1'b0;
        end else begin
          row_open <= 1'b1;
          row_q    <= addr;
          cas_seen <= 1'b0;
        end
      end
      if (ras_rise) begin
        row_open <= 1'b0;
        if (row_open && !cas_seen) test_mode <= 1'b0;
      end
      if (cas_fall) begin
        cas_seen <= 1'b1;
        col_q    <= addr;
        wr_cyc   <= ~we_n;
        if (we_n) begin
          rd_valid <= 1'b1;
          rd_data  <= rd_nib;
        end
      end
      if (cas_rise) begin
        rd_valid <= 1'b0;
        wr_cyc   <= 1'b0;
      end
    end
  end

  assign dq_oe  = rd_valid & ~oe_n;
  assign dq_out = rd_data;

  p_early_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc |-> !dq_oe);
  p_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && !we_n) |=> test_mode);
  p_cbr_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && we_n) |=> !test_mode);
  p_rasonly_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise && row_open && !cas_seen) |=> !test_mode);
  p_hidden_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && !cas_q && rd_valid) |=> (rd_valid && $stable(dq_out)));
  p_test_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && test_mode && we_n) |=> (dq_out[2:0] == 3'b111));
  p_rmw_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !cas_n && !cas_q && we_fall) |=> $stable(dq_out));
  p_oe_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cas_rise |=> !dq_oe);
endmodule

// File: tb/test_dram_test_ctrl.sv
module test_dram_test_ctrl;
  localparam int AW = 5;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_WCBR = 3'd2,
                         OP_CBR = 3'd3, OP_RORF = 3'd4, OP_HID = 3'd5, OP_RMW = 3'd6;

  typedef struct packed {
    logic [2:0] op;
    logic [4:0] row;
    logic [4:0] col;
    logic [3:0] din;
    logic [3:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{OP_WR,   5'd3,  5'd4,  4'hA, 4'h0, 4'd2},   // R2
    '{OP_WR,   5'd3,  5'd5,  4'h5, 4'h0, 4'd2},   // R2
    '{OP_RD,   5'd3,  5'd4,  4'h0, 4'hA, 4'd2},   // R2
    '{OP_RD,   5'd3,  5'd5,  4'h0, 4'h5, 4'd2},   // R2
    '{OP_WCBR, 5'd0,  5'd0,  4'h0, 4'h0, 4'd4},   // R4
    '{OP_RD,   5'd3,  5'd4,  4'h0, 4'h7, 4'd9},   // R9 byte 5A unequal
    '{OP_WR,   5'd19, 5'd21, 4'hE, 4'h0, 4'd10},  // R10 masked to byte {3,2}
    '{OP_RD,   5'd3,  5'd4,  4'h0, 4'hF, 4'd8},   // R8 byte all zero
    '{OP_CBR,  5'd0,  5'd0,  4'h0, 4'h0, 4'd5},   // R5
    '{OP_RD,   5'd3,  5'd4,  4'h0, 4'h0, 4'd5},   // R5
    '{OP_RD,   5'd3,  5'd5,  4'h0, 4'h0, 4'd8},   // R8
    '{OP_WR,   5'd19, 5'd21, 4'h9, 4'h0, 4'd10},  // R10
    '{OP_RD,   5'd3,  5'd5,  4'h0, 4'h0, 4'd10},  // R10
    '{OP_RD,   5'd19, 5'd21, 4'h0, 4'h9, 4'd10},  // R10
    '{OP_WCBR, 5'd0,  5'd0,  4'h0, 4'h0, 4'd4},   // R4
    '{OP_WR,   5'd3,  5'd4,  4'h1, 4'h0, 4'd8},   // R8 byte FF
    '{OP_RORF, 5'd7,  5'd0,  4'h0, 4'h0, 4'd6},   // R6
    '{OP_RD,   5'd19, 5'd21, 4'h0, 4'h9, 4'd6},   // R6
    '{OP_WCBR, 5'd0,  5'd0,  4'h0, 4'h0, 4'd4},   // R4
    '{OP_HID,  5'd3,  5'd5,  4'h0, 4'hF, 4'd7},   // R7
    '{OP_RD,   5'd19, 5'd21, 4'h0, 4'h9, 4'd7},   // R7
    '{OP_RMW,  5'd3,  5'd4,  4'h6, 4'hF, 4'd11},  // R11
    '{OP_RD,   5'd3,  5'd4,  4'h0, 4'h6, 4'd11},  // R11
    '{OP_RD,   5'd3,  5'd5,  4'h0, 4'hF, 4'd11},  // R11
    '{OP_WCBR, 5'd0,  5'd0,  4'h0, 4'h0, 4'd4},   // R4
    '{OP_RD,   5'd3,  5'd4,  4'h0, 4'h7, 4'd9},   // R9 byte F6 unequal
    '{OP_CBR,  5'd0,  5'd0,  4'h0, 4'h0, 4'd5}    // R5
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [3:0] dq_in = '0;
  logic [3:0] dq_out;
  logic dq_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_test_ctrl #(.AW(AW)) i_dram_test_ctrl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got oe/data %b_%h expected %b_%h", tag, act[4], act[3:0], exp[4], exp[3:0]);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic idle();
    ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1; tick(); tick();
  endtask

  task automatic do_write(input string tag, input logic [4:0] r, input logic [4:0] c, input logic [3:0] d);
    addr = r; ras_n = 0; tick();
    addr = c; we_n = 0; dq_in = d; cas_n = 0; tick();
    chk({tag, " early write keeps bus off (R3)"}, {dq_oe, 4'h0}, 5'h00);
    cas_n = 1; we_n = 1; tick();
    idle();
  endtask

  task automatic do_read(input string tag, input logic [4:0] r, input logic [4:0] c, input logic [3:0] e);
    addr = r; ras_n = 0; tick();
    addr = c; oe_n = 0; cas_n = 0; tick();
    chk(tag, {dq_oe, dq_out}, {1'b1, e});
    cas_n = 1; tick();
    idle();
  endtask

  task automatic do_cbr(input logic w);
    cas_n = 0; we_n = w; tick();
    ras_n = 0; tick();
    cas_n = 1; we_n = 1; tick();
    idle();
  endtask

  task automatic do_hidden(input string tag, input logic [4:0] r, input logic [4:0] c, input logic [3:0] e);
    addr = r; ras_n = 0; tick();
    addr = c; oe_n = 0; cas_n = 0; tick();
    chk(tag, {dq_oe, dq_out}, {1'b1, e});
    ras_n = 1; tick();
    ras_n = 0; tick();
    chk({tag, " data held through hidden refresh"}, {dq_oe, dq_out}, {1'b1, e});
    ras_n = 1; tick();
    idle();
  endtask

  task automatic do_rmw(input string tag, input logic [4:0] r, input logic [4:0] c,
                        input logic [3:0] d, input logic [3:0] e);
    addr = r; ras_n = 0; tick();
    addr = c; oe_n = 0; cas_n = 0; tick();
    chk({tag, " read part"}, {dq_oe, dq_out}, {1'b1, e});
    we_n = 0; dq_in = d; tick();
    chk({tag, " output held during write"}, {dq_oe, dq_out}, {1'b1, e});
    cas_n = 1; we_n = 1; tick();
    idle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1; tick();
    chk("R1 reset: bus off", {dq_oe, 4'h0}, 5'h00);
    do_write("R1", 5'd0, 5'd0, 4'h3);
    do_read("R1 normal mode after reset", 5'd0, 5'd0, 4'h3);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d entry %0d", TBL[i].req, i);
      case (TBL[i].op)
        OP_WR:   do_write(tag, TBL[i].row, TBL[i].col, TBL[i].din);
        OP_RD:   do_read(tag, TBL[i].row, TBL[i].col, TBL[i].exp);
        OP_WCBR: do_cbr(1'b0);
        OP_CBR:  do_cbr(1'b1);
        OP_RORF: begin addr = TBL[i].row; ras_n = 0; tick(); tick(); idle(); end
        OP_HID:  do_hidden(tag, TBL[i].row, TBL[i].col, TBL[i].exp);
        default: do_rmw(tag, TBL[i].row, TBL[i].col, TBL[i].din, TBL[i].exp);
      endcase
    end

    // R12: output enable gating and release at column strobe rise
    addr = 5'd3; ras_n = 0; tick();
    addr = 5'd4; cas_n = 0; tick();
    chk("R12 oe_n high keeps bus off", {dq_oe, 4'h0}, 5'h00);
    oe_n = 0; #1;
    chk("R12 oe_n low drives data", {dq_oe, dq_out}, {1'b1, 4'h6});
    tick();
    cas_n = 1; tick();
    chk("R12 bus off after column strobe rise", {dq_oe, 4'h0}, 5'h00);
    idle();

    // R13: fast page, one row strobe, several columns
    addr = 5'd3; ras_n = 0; tick();
    addr = 5'd4; oe_n = 0; cas_n = 0; tick();
    chk("R13 page access 1", {dq_oe, dq_out}, {1'b1, 4'h6});
    cas_n = 1; tick();
    addr = 5'd5; cas_n = 0; tick();
    chk("R13 page access 2", {dq_oe, dq_out}, {1'b1, 4'hF});
    cas_n = 1; tick();
    addr = 5'd4; we_n = 0; dq_in = 4'h2; cas_n = 0; tick();
    cas_n = 1; we_n = 1; tick();
    addr = 5'd4; cas_n = 0; tick();
    chk("R13 page write then read", {dq_oe, dq_out}, {1'b1, 4'h2});
    cas_n = 1; tick();
    idle();
    do_read("R13 upper lane untouched", 5'd3, 5'd5, 4'hF);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule